// File: doc/BRIEF.md
# Double-Rate Burst Read Port

This block is the read side of a synchronous burst memory. The port clock runs at twice the word rate, and consecutive ticks stand for the rising and falling edges of the slower interface clock. Tick kinds alternate: positive, negative, positive, and so on. A read is requested by holding the select high at a positive tick, and the address is captured at that tick. The port then returns four words from the addressed row, lowest word first, one word per tick. A valid strobe marks each word.

A mode input selects the delay before the first word. In long mode the delay is two and a half interface cycles, which is five ticks. In short mode it is one interface cycle, which is two ticks. A new read can start on every other positive tick. When reads start at that rate, the output words follow one another with no gap.

A request at the positive tick right after an accepted one is dropped without any notice. The output enable stays high while bursts are pending. It falls at the first negative tick after the last word. The backing store is four internal banks, one per word position in the burst. They are loaded at reset with a fixed pattern, so every word can be predicted.

Top module: `dbl_burst_rd_port`

## Requirements
- R1: During and right after synchronous reset, `q_valid`, `q_oe` and `q_data` are zero and `q_phase` is 0, so the first tick after reset is a positive tick. After each tick, `q_phase` gives the kind of the next tick (0 positive, 1 negative).
- R2: A read is accepted only at a positive tick where `rd_sel` is 1. The value of `rd_sel` at a negative tick has no effect on the outputs.
- R3: An accepted read at address a returns words w0, w1, w2, w3 on four consecutive ticks, with `q_valid` high on each. Word j is a 36-bit value: bits 7:0 hold k = {a, j[1:0]} and bits 35:28 hold ~k, with all other bits zero (default widths).
- R4: With `lat_full` = 1, w0 appears on the outputs after the fifth tick that follows the accepting tick (2.5 interface cycles).
- R5: With `lat_full` = 0, w0 appears after the second tick that follows the accepting tick (1 interface cycle).
- R6: A request at the positive tick right after an accepted read is dropped and yields no words.
- R7: Requests held high on every positive tick are accepted on alternate positive ticks. The output then carries an unbroken stream of valid words.
- R8: `q_oe` rises together with the first word. It stays high while words are being sent, and it falls at the first negative tick after the last word.
- R9: `q_data` is zero on every tick where `q_valid` is low, and therefore whenever `q_oe` is low.
- R10: After `rd_sel` is dropped, every read already accepted still delivers all four words.
- R11: A synchronous reset during a burst cancels all pending and in-flight words and clears the spacing state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; ticks alternate positive and negative |
| rst | input | 1 | Synchronous reset, active high |
| lat_full | input | 1 | 1: 2.5-cycle latency, 0: 1-cycle latency; change only while idle |
| rd_sel | input | 1 | Read request, sampled at positive ticks |
| rd_addr | input | AW (6) | Row address captured with an accepted request |
| q_data | output | DW (36) | Output word, zero when not valid |
| q_valid | output | 1 | Marks a valid burst word |
| q_oe | output | 1 | Output enable |
| q_phase | output | 1 | Kind of the next tick: 0 positive, 1 negative |

## Verification
A single isolated request shows where the first word lands in each latency mode. Comparing the two modes tells the five-tick delay apart from the two-tick delay. A request held high across positive and negative ticks shows that only alternate positive ticks are accepted and that the resulting bursts join with no gap. Requests placed only on negative ticks, and a request placed right after an accepted one, must leave the output unchanged. A reset in the middle of a burst, and the tail after the select drops, show when the enable falls and which pending words still arrive.

// File: rtl/dbrp_pkg.sv
`timescale 1ns/1ps
package dbrp_pkg;
  localparam int BURST_WORDS = 4;
  localparam int BEAT_W      = $clog2(BURST_WORDS);
  localparam int LONG_TICKS  = 5;
  localparam int SHORT_TICKS = 2;
endpackage

// File: rtl/dbrp_bank.sv
`timescale 1ns/1ps
module dbrp_bank #(
  parameter int AW  = 6,
  parameter int DW  = 36,
  parameter int IDX = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  localparam int KW    = AW + dbrp_pkg::BEAT_W;

  function automatic logic [DW-1:0] fill_word(input logic [AW-1:0] a,
                                              input logic [dbrp_pkg::BEAT_W-1:0] j);
    logic [KW-1:0] k;
    k = {a, j};
    fill_word = '0;
    fill_word[KW-1:0] = k;
    fill_word[DW-1 -: KW] = ~k;
  endfunction

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= fill_word(AW'(i), dbrp_pkg::BEAT_W'(IDX));
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dbrp_req_gate.sv
`timescale 1ns/1ps
module dbrp_req_gate (
  input  logic clk,
  input  logic rst,
  input  logic rd_sel,
  output logic ph,
  output logic acc_evt
);
  logic last_acc;

  assign acc_evt = !ph && rd_sel && !last_acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= 1'b0;
      last_acc <= 1'b0;
    end else begin
      ph <= ~ph;
      if (!ph) last_acc <= acc_evt;
    end
  end
endmodule

// File: rtl/dbrp_launch_line.sv
`timescale 1ns/1ps
module dbrp_launch_line #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_evt,
  input  logic          lat_full,
  input  logic [AW-1:0] acc_addr,
  output logic          launch,
  output logic          launch_full,
  output logic [AW-1:0] launch_addr
);
  localparam int DEPTH = dbrp_pkg::LONG_TICKS;
  localparam int TAP_L = dbrp_pkg::LONG_TICKS - 1;
  localparam int TAP_S = dbrp_pkg::SHORT_TICKS - 1;

  logic [DEPTH-1:0] v;
  logic [DEPTH-1:0] f;
  logic [AW-1:0]    a [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      v    <= '0;
      f    <= '0;
      a[0] <= '0;
    end else begin
      v[0] <= acc_evt;
      f[0] <= lat_full;
      a[0] <= acc_addr;
    end
  end

  for (genvar s = 1; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        a[s] <= '0;
      end else begin
        v[s] <= v[s-1];
        f[s] <= f[s-1];
        a[s] <= a[s-1];
      end
    end
  end

  logic hit_s, hit_l;
  assign hit_s = v[TAP_S] && !f[TAP_S];
  assign hit_l = v[TAP_L] && f[TAP_L];

  always_comb begin
    launch      = hit_s || hit_l;
    launch_full = !hit_s && hit_l;
    launch_addr = hit_s ? a[TAP_S] : a[TAP_L];
  end
endmodule

// File: rtl/dbrp_beat_out.sv
`timescale 1ns/1ps
module dbrp_beat_out #(
  parameter int AW = 6,
  parameter int DW = 36
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        ph,
  input  logic                        launch,
  input  logic [AW-1:0]               launch_addr,
  input  logic [DW-1:0]               word_in,
  output logic [AW-1:0]               fetch_addr,
  output logic [dbrp_pkg::BEAT_W-1:0] fetch_beat,
  output logic [DW-1:0]               q_data,
  output logic                        q_valid,
  output logic                        q_oe
);
  localparam logic [dbrp_pkg::BEAT_W-1:0] LAST = dbrp_pkg::BEAT_W'(dbrp_pkg::BURST_WORDS - 1);

  logic                        active;
  logic [dbrp_pkg::BEAT_W-1:0] beat;
  logic [AW-1:0]               cur_addr;
  logic                        word_next;

  assign fetch_addr = launch ? launch_addr : cur_addr;
  assign fetch_beat = launch ? '0 : beat;
  assign word_next  = launch || active;

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      beat     <= '0;
      cur_addr <= '0;
      q_data   <= '0;
      q_valid  <= 1'b0;
    end else if (launch) begin
      active   <= 1'b1;
      beat     <= dbrp_pkg::BEAT_W'(1);
      cur_addr <= launch_addr;
      q_data   <= word_in;
      q_valid  <= 1'b1;
    end else if (active) begin
      active   <= (beat != LAST);
      beat     <= beat + dbrp_pkg::BEAT_W'(1);
      q_data   <= word_in;
      q_valid  <= 1'b1;
    end else begin
      q_data   <= '0;
      q_valid  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            q_oe <= 1'b0;
    else if (word_next) q_oe <= 1'b1;
    else if (ph)        q_oe <= 1'b0;
  end
endmodule

// File: rtl/dbl_burst_rd_port.sv
`timescale 1ns/1ps
module dbl_burst_rd_port #(
  parameter int AW = 6,
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lat_full,
  input  logic          rd_sel,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] q_data,
  output logic          q_valid,
  output logic          q_oe,
  output logic          q_phase
);
  localparam int NB = dbrp_pkg::BURST_WORDS;

  logic                        ph, acc_evt;
  logic                        launch_evt, launch_full;
  logic [AW-1:0]               launch_addr, fetch_addr;
  logic [dbrp_pkg::BEAT_W-1:0] fetch_beat;
  logic [DW-1:0]               bank_word [NB];
  logic [DW-1:0]               word_sel;

  dbrp_req_gate u_gate (
    .clk(clk), .rst(rst), .rd_sel(rd_sel), .ph(ph), .acc_evt(acc_evt)
  );

  dbrp_launch_line #(.AW(AW)) u_line (
    .clk(clk), .rst(rst), .acc_evt(acc_evt), .lat_full(lat_full),
    .acc_addr(rd_addr), .launch(launch_evt), .launch_full(launch_full),
    .launch_addr(launch_addr)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    dbrp_bank #(.AW(AW), .DW(DW), .IDX(b)) u_bank (
      .clk(clk), .rst(rst), .raddr(fetch_addr), .rdata(bank_word[b])
    );
  end

  assign word_sel = bank_word[fetch_beat];

  dbrp_beat_out #(.AW(AW), .DW(DW)) u_out (
    .clk(clk), .rst(rst), .ph(ph), .launch(launch_evt),
    .launch_addr(launch_addr), .word_in(word_sel),
    .fetch_addr(fetch_addr), .fetch_beat(fetch_beat),
    .q_data(q_data), .q_valid(q_valid), .q_oe(q_oe)
  );

  assign q_phase = ph;

  // R6
  accept_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    acc_evt |=> ##1 !acc_evt);

  // R4
  launch_phase_chk: assert property (@(posedge clk) disable iff (rst)
    launch_evt |-> (ph == launch_full));

  // R8
  valid_has_oe_chk: assert property (@(posedge clk) disable iff (rst)
    q_valid |-> q_oe);

  // R8
  oe_drop_neg_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(q_oe) |-> !ph);

  // R9
  idle_data_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !q_valid |-> (q_data == '0));
endmodule

// File: tb/dbl_burst_rd_port_test.sv
`timescale 1ns/1ps
module dbl_burst_rd_port_test;
  localparam int AW = 6;
  localparam int DW = 36;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          lat_full = 1'b1;
  logic          rd_sel = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] q_data;
  logic          q_valid, q_oe, q_phase;

  int total = 0;
  int fails = 0;
  bit done = 0;
  int n = 0;
  bit last_acc = 0;
  logic [DW-1:0] sched [int];
  string tag = "R1";

  always #2.5 clk = ~clk;

  dbl_burst_rd_port #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst(rst), .lat_full(lat_full), .rd_sel(rd_sel),
    .rd_addr(rd_addr), .q_data(q_data), .q_valid(q_valid),
    .q_oe(q_oe), .q_phase(q_phase)
  );

  function automatic logic [DW-1:0] ref_word(input int a, input int j);
    int k;
    k = (a * 4 + j) & 255;
    return DW'(k) + (DW'(255 - k) << 28);
  endfunction

  task automatic chk(input string req, input string what, input logic [DW-1:0] act,
                     input logic [DW-1:0] expv);
    total++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s at tick %0d: actual %h expected %h", req, what, n, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  task automatic compare();
    bit v, prev;
    logic [DW-1:0] d;
    v    = sched.exists(n);
    d    = v ? sched[n] : '0;
    prev = sched.exists(n - 1) && ((n - 1) % 2 == 1);
    chk(tag, "q_valid", DW'(q_valid), DW'(v));
    chk(tag, "q_data", q_data, d);
    chk(tag, "q_oe", DW'(q_oe), DW'(v || prev));
    chk("R1", "q_phase", DW'(q_phase), DW'((n + 1) % 2));
  endtask

  task automatic step(input bit sel, input int a);
    bit acc;
    int lat;
    rd_sel  = sel;
    rd_addr = AW'(a);
    @(posedge clk);
    if (n % 2 == 0) begin
      acc = sel && !last_acc;
      last_acc = acc;
      lat = lat_full ? 5 : 2;
      if (acc) for (int j = 0; j < 4; j++) sched[n + lat + j] = ref_word(a, j);
    end
    @(negedge clk);
    compare();
    n++;
  endtask

  task automatic idle(input int cnt);
    for (int i = 0; i < cnt; i++) step(0, 0);
  endtask

  task automatic to_even();
    if (n % 2 == 1) step(0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired: actual hung expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", "reset q_valid", DW'(q_valid), '0);
    chk("R1", "reset q_oe", DW'(q_oe), '0);
    chk("R1", "reset q_data", q_data, '0);
    chk("R1", "reset q_phase", DW'(q_phase), '0);
    rst = 1'b0;

    // R4 single read, long latency; R3 word order
    tag = "R4";
    step(1, 3);
    idle(12);

    // R2 requests only on negative ticks are ignored
    tag = "R2";
    to_even();
    step(0, 0); step(1, 7); step(0, 0); step(1, 8);
    idle(10);

    // R6 request right after an accepted one is dropped
    tag = "R6";
    to_even();
    step(1, 5); step(0, 0); step(1, 9); step(0, 0);
    idle(12);

    // R7 held select gives a continuous stream; R10 tail drains after deselect
    tag = "R7";
    to_even();
    for (int i = 0; i < 10; i++) step(1, 10 + i);
    tag = "R10";
    idle(14);

    // R5 short latency mode, single and streamed
    lat_full = 1'b0;
    tag = "R5";
    to_even();
    step(1, 21);
    idle(8);
    tag = "R8";
    to_even();
    for (int i = 0; i < 8; i++) step(1, 40 + i);
    idle(10);
    tag = "R3";
    to_even();
    step(1, 63);
    idle(8);

    // R11 reset during a burst
    lat_full = 1'b1;
    tag = "R11";
    to_even();
    step(1, 33);
    idle(5);
    rst = 1'b1;
    rd_sel = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R11", "reset q_valid", DW'(q_valid), '0);
    chk("R11", "reset q_oe", DW'(q_oe), '0);
    chk("R11", "reset q_data", q_data, '0);
    rst = 1'b0;
    sched.delete();
    last_acc = 0;
    n = 0;
    idle(10);
    // R11 spacing state cleared: first positive tick accepts
    step(1, 2);
    idle(10);

    finish_run();
  end
endmodule